// File: doc/BRIEF.md
# Self-Test Amplitude Band Monitor

This block watches the amplitude of a sensor's built-in self-test response. Each time a new self-test difference sample arrives, it goes into a slow first-order recursive low-pass filter. The filtered amplitude is then compared with two tolerance bands, one inside the other, both centred on the expected self-test magnitude. Leaving the inner band raises a soft fault. That fault is only meant for a fault register and leaves the sensor data valid. Leaving the outer band also raises a hard fault, which switches the sensor status code to the invalid-data value.

Only the filtered amplitude can raise a fault. A short spike in the raw sample moves the filter by one sixty-fourth of its size, and that is normally far too little to cross a band edge. The filtered and raw values are both available as registered outputs, so software can read them. A separate quadrature value is checked against its own symmetric magnitude limit and drives a third flag.

Top module: `cst_monitor`

## Requirements
- R1: While reset is held and directly after it, the filtered output is 2559, the raw output is 0, the soft, hard and quadrature flags are 0, and the status code is 01.
- R2: The filter state S is signed and carries 6 fractional bits. Reset sets S to 2559·64. On every sample strobe S becomes S − floor(S/64) + x. The filtered output is floor(S/64), and it updates on the first clock edge after the strobe.
- R3: On the first clock edge after a strobe, the raw output takes the strobed sample. A single raw spike of 8000 with the filter at nominal raises no fault.
- R4: The soft flag is 1 exactly when the last compared filtered value is below 2239 or above 2879. Both band edges count as in band.
- R5: The hard flag is 1 exactly when the last compared filtered value is below 1279 or above 3839. Whenever the hard flag is 1, the soft flag is also 1.
- R6: The status code is 00 while the hard flag is 1 and 01 otherwise. It never takes the values 10 or 11.
- R7: The fault flags change only on the second clock edge after a sample strobe, and they then reflect the filtered value produced by that strobe.
- R8: On the first clock edge after a quadrature strobe, the quadrature flag becomes 1 if the strobed signed value is above 4096 or below −4096, and 0 otherwise.
- R9: When no sample strobe arrives, the filtered output, the raw output and the fault flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Self-test sample strobe |
| smp_in | input | 16 | Signed self-test difference sample |
| quad_vld | input | 1 | Quadrature sample strobe |
| quad_in | input | 16 | Signed quadrature value |
| filt_out | output | 16 | Filtered self-test amplitude |
| raw_out | output | 16 | Last raw self-test sample |
| soft_flt | output | 1 | Inner-band fault |
| hard_flt | output | 1 | Outer-band fault |
| status | output | 2 | Sensor status code (01 valid, 00 invalid) |
| quad_flt | output | 1 | Quadrature magnitude fault |

## Verification
The bench builds the block with its default parameters: a 1/64 filter pole, a 16-bit sample width, and the 2559-centred bands. With these settings, a constant input draws the filtered value onto that input exactly. A few hundred strobes therefore place the output on each band edge, and then one step beyond it. That makes all four band boundaries reachable and checkable at their exact values. The same settings leave a lone raw spike clearly too small to cross a band.

// File: rtl/cst_monitor.sv
module cst_monitor #(
  parameter int W       = 16,
  parameter int SHIFT   = 6,
  parameter int NOM     = 2559,
  parameter int SOFT_LO = 2239,
  parameter int SOFT_HI = 2879,
  parameter int HARD_LO = 1279,
  parameter int HARD_HI = 3839,
  parameter int QLIM    = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] smp_in,
  input  logic                quad_vld,
  input  logic signed [W-1:0] quad_in,
  output logic signed [W-1:0] filt_out,
  output logic signed [W-1:0] raw_out,
  output logic                soft_flt,
  output logic                hard_flt,
  output logic [1:0]          status,
  output logic                quad_flt
);
  localparam int AW = W + SHIFT;
  localparam logic signed [AW-1:0] ACC_INIT = AW'(NOM * (1 << SHIFT));

  logic signed [AW-1:0] acc, acc_nxt, acc_tap, smp_ext;
  logic signed [31:0]   fx, qx;
  logic                 cmp_vld;

  assign smp_ext  = {{SHIFT{smp_in[W-1]}}, smp_in};
  assign acc_tap  = {{SHIFT{acc[AW-1]}}, acc[AW-1:SHIFT]};
  assign acc_nxt  = acc - acc_tap + smp_ext;
  assign filt_out = acc[AW-1:SHIFT];
  assign fx       = {{(32-W){filt_out[W-1]}}, filt_out};
  assign qx       = {{(32-W){quad_in[W-1]}}, quad_in};
  assign status   = hard_flt ? 2'b00 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= ACC_INIT;
      raw_out <= '0;
      cmp_vld <= 1'b0;
    end else begin
      cmp_vld <= smp_vld;
      if (smp_vld) begin
        acc     <= acc_nxt;
        raw_out <= smp_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_flt <= 1'b0;
      hard_flt <= 1'b0;
    end else if (cmp_vld) begin
      soft_flt <= (fx < SOFT_LO) || (fx > SOFT_HI);
      hard_flt <= (fx < HARD_LO) || (fx > HARD_HI);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        quad_flt <= 1'b0;
    else if (quad_vld) quad_flt <= (qx > QLIM) || (qx < -QLIM);
  end
endmodule

// File: rtl/cst_monitor_chk.sv
module cst_monitor_chk #(
  parameter int W    = 16,
  parameter int QLIM = 4096
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_vld,
  input logic signed [W-1:0] smp_in,
  input logic                quad_vld,
  input logic signed [W-1:0] quad_in,
  input logic signed [W-1:0] filt_out,
  input logic signed [W-1:0] raw_out,
  input logic                soft_flt,
  input logic                hard_flt,
  input logic [1:0]          status,
  input logic                quad_flt
);
  // R5
  hard_implies_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_flt |-> soft_flt);

  // R6
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && !hard_flt) || (status == 2'b00 && hard_flt));

  // R3
  raw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> raw_out == $past(smp_in));

  // R9
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(smp_vld)) |-> ($stable(filt_out) && $stable(raw_out)));

  // R2
  filt_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(smp_vld) && ($past(smp_in) >= $past(filt_out)))
      |-> filt_out >= $past(filt_out));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(smp_vld, 2)) |-> ($stable(soft_flt) && $stable(hard_flt)));

  // R8
  quad_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quad_vld |=> quad_flt == (($past(quad_in) > QLIM) || ($past(quad_in) < -QLIM)));
endmodule

bind cst_monitor cst_monitor_chk #(.W(W), .QLIM(QLIM)) u_chk (.*);

// File: tb/cst_monitor_test.sv
`timescale 1ns/1ps
module cst_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [15:0] smp_in = '0;
  logic quad_vld = 1'b0;
  logic signed [15:0] quad_in = '0;
  logic signed [15:0] filt_out, raw_out;
  logic soft_flt, hard_flt, quad_flt;
  logic [1:0] status;

  int errors = 0;
  int checks = 0;
  int s;
  bit e_soft = 0, e_hard = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cst_monitor uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_y();
    return s >>> 6;
  endfunction

  task automatic push(input int x);
    int y;
    bit ps, ph;
    @(negedge clk);
    smp_vld = 1'b1; smp_in = 16'(x);
    @(negedge clk);
    smp_vld = 1'b0;
    s = s - (s >>> 6) + x;
    y = model_y();
    chk("R2 filtered", int'(filt_out), y);
    chk("R3 raw", int'(raw_out), x);
    ps = e_soft; ph = e_hard;
    chk("R7 soft not yet", int'(soft_flt), int'(ps));
    chk("R7 hard not yet", int'(hard_flt), int'(ph));
    @(negedge clk);
    e_soft = (y < 2239) || (y > 2879);
    e_hard = (y < 1279) || (y > 3839);
    chk("R4 soft", int'(soft_flt), int'(e_soft));
    chk("R5 hard", int'(hard_flt), int'(e_hard));
    chk("R6 status", int'(status), e_hard ? 0 : 1);
  endtask

  task automatic settle(input int x, input int n);
    for (int i = 0; i < n; i++) push(x);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 filt", int'(filt_out), 2559);
    chk("R1 raw", int'(raw_out), 0);
    chk("R1 soft", int'(soft_flt), 0);
    chk("R1 hard", int'(hard_flt), 0);
    chk("R1 quad", int'(quad_flt), 0);
    chk("R1 status", int'(status), 1);
    rst_n = 1'b1;
    s = 2559 * 64; e_soft = 0; e_hard = 0;
    @(negedge clk);
    chk("R1 filt after release", int'(filt_out), 2559);
  endtask

  task automatic t_spike();
    push(8000);
    chk("R3 spike no soft", int'(soft_flt), 0);
    chk("R3 spike no hard", int'(hard_flt), 0);
    settle(2559, 400);
  endtask

  task automatic t_edge(input string req, input int inb, input int outb,
                        input bit soft_out, input bit hard_out);
    settle(inb, 1500);
    chk({req, " edge value"}, int'(filt_out), inb);
    chk({req, " edge soft"}, int'(soft_flt), 0 + int'(hard_out && 1'b1 && (inb > 3839 || inb < 1279 || inb > 2879 || inb < 2239)));
    settle(outb, 1500);
    chk({req, " beyond value"}, int'(filt_out), outb);
    chk({req, " beyond soft"}, int'(soft_flt), int'(soft_out));
    chk({req, " beyond hard"}, int'(hard_flt), int'(hard_out));
    settle(2559, 1500);
  endtask

  task automatic t_hold();
    int f; int r; bit so; bit ha;
    push(2700);
    f = int'(filt_out); r = int'(raw_out); so = soft_flt; ha = hard_flt;
    smp_in = 16'sd30000;
    repeat (20) @(negedge clk);
    chk("R9 filt held", int'(filt_out), f);
    chk("R9 raw held", int'(raw_out), r);
    chk("R9 soft held", int'(soft_flt), int'(so));
    chk("R9 hard held", int'(hard_flt), int'(ha));
  endtask

  task automatic qpush(input int q, input bit exp);
    @(negedge clk);
    quad_vld = 1'b1; quad_in = 16'(q);
    @(negedge clk);
    quad_vld = 1'b0; quad_in = '0;
    chk("R8 quad", int'(quad_flt), int'(exp));
    @(negedge clk);
    chk("R8 quad held", int'(quad_flt), int'(exp));
  endtask

  task automatic t_quad();
    qpush(4096, 0);
    qpush(4097, 1);
    qpush(0, 0);
    qpush(-4096, 0);
    qpush(-4097, 1);
    qpush(-32768, 1);
    qpush(100, 0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_spike();
    t_edge("R4 upper", 2879, 2880, 1, 0);
    t_edge("R4 lower", 2239, 2238, 1, 0);
    t_edge("R5 upper", 3839, 3840, 1, 1);
    t_edge("R5 lower", 1279, 1278, 1, 1);
    t_quad();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule